// File: doc/BRIEF.md
# Snapshot-Checkpoint Register Alias Table

This block renames one three-operand instruction per cycle. It keeps a main mapping table, indexed by architectural register number, whose entries hold physical register names. In each cycle it returns the mappings of two source registers and the current mapping of the destination register. The destination mapping is the one that a reorder buffer keeps so that the physical register can later be freed. If the instruction writes a destination, the new physical register supplied with it is written into the table at the clock edge.

Speculation is handled with full shadow copies. An instruction that opens new speculation, such as a branch, asks for a checkpoint. The block picks a free checkpoint slot, returns its tag, and copies the whole main table into that slot in the same edge. The copy is the table state from before that instruction's own destination write. On a misprediction the caller names a tag, and the block copies that slot back over the main table in one cycle. Every checkpoint taken after the restored one is dropped. A slot that is no longer needed is returned with a release request. The free list and the reorder buffer sit outside this block.

Top module: `snap_rat`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i.
- R2: The source and previous-destination outputs are combinational reads of the main table as it stands before the current instruction's own write. An instruction that reads and writes the same register therefore sees the old mapping.
- R3: An accepted rename with the destination-write flag set installs the new physical register, and a read of that register sees it from the next cycle on. A rename is accepted when it is valid, has no stall and has no recovery in the same cycle. With the valid flag low, or the destination-write flag low, the table does not change.
- R4: An accepted rename that requests a checkpoint is granted the lowest-numbered free slot. The grant and the tag appear in the same cycle. The slot's snapshot holds the table from before that instruction's destination write.
- R5: When all slots are in use, a rename that requests a checkpoint raises the stall output. It gets no grant and writes nothing.
- R6: A recovery to a valid tag makes the main table equal to that slot's snapshot from the next cycle on. A rename presented in the same cycle as a recovery request has no effect.
- R7: A recovery keeps the restored slot and every slot allocated before it. It frees every slot allocated after it, whatever the slot numbers are.
- R8: A release frees the named slot, so it can be granted again. A recovery that names a free slot changes neither the table nor the slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | A rename is presented this cycle |
| rn_src1 | input | 5 | First source architectural register |
| rn_src2 | input | 5 | Second source architectural register |
| rn_dst | input | 5 | Destination architectural register |
| rn_dst_wr | input | 1 | Instruction writes its destination |
| rn_new_preg | input | 6 | New physical register for the destination |
| rn_ckpt | input | 1 | Instruction opens new speculation and needs a checkpoint |
| rec_valid | input | 1 | Misprediction recovery request |
| rec_tag | input | 2 | Checkpoint slot to restore |
| rel_valid | input | 1 | Checkpoint release request |
| rel_tag | input | 2 | Checkpoint slot to free |
| rn_stall | output | 1 | Checkpoint requested but no slot is free |
| rn_src1_preg | output | 6 | Physical mapping of the first source |
| rn_src2_preg | output | 6 | Physical mapping of the second source |
| rn_prev_preg | output | 6 | Current mapping of the destination before the write |
| ck_grant | output | 1 | Checkpoint granted this cycle |
| ck_tag | output | 2 | Tag of the granted slot |

## Verification
The hardest case to reach is a recovery where the age order of the live checkpoints does not follow slot-number order. In that case pruning by index would free the wrong slots. The stimulus fills every slot, releases a low-numbered one and has it granted again, so that slot becomes the youngest. It then recovers to a middle slot and checks three things: which tags the next requests receive, when the stall appears, and what the source reads return. A later recovery to a freed slot checks that nothing changes.

// File: rtl/snap_rat_pkg.sv
`timescale 1ns/1ps
package snap_rat_pkg;
    localparam int unsigned DEF_ARCH = 32;
    localparam int unsigned DEF_PHYS = 64;
    localparam int unsigned DEF_CKPT = 4;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/snap_rat_maps.sv
`timescale 1ns/1ps
module snap_rat_maps
    import snap_rat_pkg::*;
#(
    parameter int unsigned ARCH = DEF_ARCH,
    parameter int unsigned PHYS = DEF_PHYS,
    parameter int unsigned CKPT = DEF_CKPT,
    localparam int unsigned AW = idx_bits(ARCH),
    localparam int unsigned PW = idx_bits(PHYS),
    localparam int unsigned TW = idx_bits(CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_c_idx,
    output logic [PW-1:0] rd_a,
    output logic [PW-1:0] rd_b,
    output logic [PW-1:0] rd_c,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_data,
    input  logic          save_en,
    input  logic [TW-1:0] save_tag,
    input  logic          restore_en,
    input  logic [TW-1:0] restore_tag
);
    typedef logic [PW-1:0] preg_t;
    typedef struct packed {
        preg_t [ARCH-1:0]           main;
        preg_t [CKPT-1:0][ARCH-1:0] snap;
    } maps_t;

    function automatic maps_t reset_val();
        maps_t v;
        v = '0;
        for (int i = 0; i < int'(ARCH); i++) begin
            v.main[i] = preg_t'(i);
        end
        return v;
    endfunction

    localparam maps_t RST = reset_val();

    maps_t st_d, st_q;

    // Snapshot always takes the pre-write table; restore wins over the rename write.
    always_comb begin
        st_d = st_q;
        if (restore_en) begin
            st_d.main = st_q.snap[restore_tag];
        end else if (wr_en) begin
            st_d.main[wr_idx] = wr_data;
        end
        if (save_en) begin
            st_d.snap[save_tag] = st_q.main;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign rd_a = st_q.main[rd_a_idx];
    assign rd_b = st_q.main[rd_b_idx];
    assign rd_c = st_q.main[rd_c_idx];
endmodule

// File: rtl/snap_rat_slots.sv
`timescale 1ns/1ps
module snap_rat_slots
    import snap_rat_pkg::*;
#(
    parameter int unsigned CKPT = DEF_CKPT,
    localparam int unsigned TW = idx_bits(CKPT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic            release_valid,
    input  logic [TW-1:0]   release_tag,
    input  logic            recover_valid,
    input  logic [TW-1:0]   recover_tag,
    output logic            any_free,
    output logic            alloc_grant,
    output logic [TW-1:0]   alloc_tag,
    output logic            recover_ok,
    output logic [CKPT-1:0] slot_valid
);
    // younger[r][j] set: slot j was allocated while slot r was live.
    typedef struct packed {
        logic [CKPT-1:0]            valid;
        logic [CKPT-1:0][CKPT-1:0]  younger;
    } slots_t;

    slots_t st_d, st_q;
    logic [TW-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = int'(CKPT) - 1; i >= 0; i--) begin
            if (!st_q.valid[i]) pick = TW'(i);
        end
        any_free    = ~&st_q.valid;
        alloc_grant = alloc_req && any_free;
        recover_ok  = recover_valid && st_q.valid[recover_tag];

        st_d = st_q;
        if (release_valid) begin
            st_d.valid[release_tag] = 1'b0;
        end
        if (recover_ok) begin
            st_d.valid = st_d.valid & ~st_q.younger[recover_tag];
        end
        if (alloc_grant) begin
            st_d.valid[pick]   = 1'b1;
            st_d.younger[pick] = '0;
            for (int j = 0; j < int'(CKPT); j++) begin
                if (j != int'(pick)) st_d.younger[j][pick] = st_q.valid[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_tag  = pick;
    assign slot_valid = st_q.valid;
endmodule

// File: rtl/snap_rat.sv
`timescale 1ns/1ps
module snap_rat
    import snap_rat_pkg::*;
#(
    parameter int unsigned ARCH = DEF_ARCH,
    parameter int unsigned PHYS = DEF_PHYS,
    parameter int unsigned CKPT = DEF_CKPT,
    localparam int unsigned AW = idx_bits(ARCH),
    localparam int unsigned PW = idx_bits(PHYS),
    localparam int unsigned TW = idx_bits(CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rn_valid,
    input  logic [AW-1:0] rn_src1,
    input  logic [AW-1:0] rn_src2,
    input  logic [AW-1:0] rn_dst,
    input  logic          rn_dst_wr,
    input  logic [PW-1:0] rn_new_preg,
    input  logic          rn_ckpt,
    input  logic          rec_valid,
    input  logic [TW-1:0] rec_tag,
    input  logic          rel_valid,
    input  logic [TW-1:0] rel_tag,
    output logic          rn_stall,
    output logic [PW-1:0] rn_src1_preg,
    output logic [PW-1:0] rn_src2_preg,
    output logic [PW-1:0] rn_prev_preg,
    output logic          ck_grant,
    output logic [TW-1:0] ck_tag
);
    logic            any_free;
    logic            rec_ok;
    logic            accept;
    logic [CKPT-1:0] slot_valid;

    assign rn_stall = rn_valid && rn_ckpt && !any_free;
    assign accept   = rn_valid && !rec_valid && !rn_stall;

    snap_rat_slots #(.CKPT(CKPT)) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_req     (rn_valid && rn_ckpt && !rec_valid),
        .release_valid (rel_valid),
        .release_tag   (rel_tag),
        .recover_valid (rec_valid),
        .recover_tag   (rec_tag),
        .any_free      (any_free),
        .alloc_grant   (ck_grant),
        .alloc_tag     (ck_tag),
        .recover_ok    (rec_ok),
        .slot_valid    (slot_valid)
    );

    snap_rat_maps #(.ARCH(ARCH), .PHYS(PHYS), .CKPT(CKPT)) u_maps (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_a_idx    (rn_src1),
        .rd_b_idx    (rn_src2),
        .rd_c_idx    (rn_dst),
        .rd_a        (rn_src1_preg),
        .rd_b        (rn_src2_preg),
        .rd_c        (rn_prev_preg),
        .wr_en       (accept && rn_dst_wr),
        .wr_idx      (rn_dst),
        .wr_data     (rn_new_preg),
        .save_en     (ck_grant),
        .save_tag    (ck_tag),
        .restore_en  (rec_ok),
        .restore_tag (rec_tag)
    );
endmodule

// File: rtl/snap_rat_chk.sv
`timescale 1ns/1ps
module snap_rat_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned PW = 6,
    parameter int unsigned TW = 2,
    parameter int unsigned CKPT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rn_valid,
    input logic            rn_ckpt,
    input logic            rn_dst_wr,
    input logic [AW-1:0]   rn_dst,
    input logic [AW-1:0]   rn_src1,
    input logic [PW-1:0]   rn_src1_preg,
    input logic [PW-1:0]   rn_new_preg,
    input logic            rn_stall,
    input logic            rec_valid,
    input logic [TW-1:0]   rec_tag,
    input logic            rec_ok,
    input logic            rel_valid,
    input logic [TW-1:0]   rel_tag,
    input logic            ck_grant,
    input logic [TW-1:0]   ck_tag,
    input logic [CKPT-1:0] slot_valid
);
    p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rn_valid && rn_dst_wr && !rn_stall && !rec_valid)
         && rn_src1 == $past(rn_dst)) |-> rn_src1_preg == $past(rn_new_preg));

    p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ck_grant |-> !slot_valid[ck_tag]);

    p_grant_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ck_grant |=> slot_valid[$past(ck_tag)]);

    p_stall_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_ckpt && (&slot_valid)) |-> (rn_stall && !ck_grant));

    p_restore_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_ok && !(rel_valid && rel_tag == rec_tag)) |=> slot_valid[$past(rec_tag)]);

    p_release_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !(ck_grant && ck_tag == rel_tag)) |=> !slot_valid[$past(rel_tag)]);
endmodule

bind snap_rat snap_rat_chk #(.AW(AW), .PW(PW), .TW(TW), .CKPT(CKPT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rn_valid     (rn_valid),
    .rn_ckpt      (rn_ckpt),
    .rn_dst_wr    (rn_dst_wr),
    .rn_dst       (rn_dst),
    .rn_src1      (rn_src1),
    .rn_src1_preg (rn_src1_preg),
    .rn_new_preg  (rn_new_preg),
    .rn_stall     (rn_stall),
    .rec_valid    (rec_valid),
    .rec_tag      (rec_tag),
    .rec_ok       (rec_ok),
    .rel_valid    (rel_valid),
    .rel_tag      (rel_tag),
    .ck_grant     (ck_grant),
    .ck_tag       (ck_tag),
    .slot_valid   (slot_valid)
);

// File: tb/snap_rat_tb.sv
`timescale 1ns/1ps
module snap_rat_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rn_valid = 1'b0, rn_dst_wr = 1'b0, rn_ckpt = 1'b0;
    logic [4:0] rn_src1 = '0, rn_src2 = '0, rn_dst = '0;
    logic [5:0] rn_new_preg = '0;
    logic       rec_valid = 1'b0, rel_valid = 1'b0;
    logic [1:0] rec_tag = '0, rel_tag = '0;
    logic       rn_stall, ck_grant;
    logic [5:0] rn_src1_preg, rn_src2_preg, rn_prev_preg;
    logic [1:0] ck_tag;

    always #2.5 clk = ~clk;

    snap_rat u_dut (
        .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_src1(rn_src1),
        .rn_src2(rn_src2), .rn_dst(rn_dst), .rn_dst_wr(rn_dst_wr),
        .rn_new_preg(rn_new_preg), .rn_ckpt(rn_ckpt), .rec_valid(rec_valid),
        .rec_tag(rec_tag), .rel_valid(rel_valid), .rel_tag(rel_tag),
        .rn_stall(rn_stall), .rn_src1_preg(rn_src1_preg), .rn_src2_preg(rn_src2_preg),
        .rn_prev_preg(rn_prev_preg), .ck_grant(ck_grant), .ck_tag(ck_tag)
    );

    typedef struct {
        int    s1, s2, pd, tag;
        bit    stall, grant;
        string req;
    } exp_t;

    exp_t  sb_q[$];
    event  drv_ev;
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;

    // Reference model of the rename state, kept from the requirements
    int mm[32];
    int mc[4][32];
    bit mv[4];
    int ser[4];
    int sctr = 0;

    task automatic check(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step(input bit rv, input int s1, input int s2, input int d,
                        input bit dw, input int np, input bit ck,
                        input bit rc, input int rt, input bit rl, input int lt,
                        input string req);
        exp_t e;
        bit   free_any, rec_ok, accept;
        int   pick;
        int   old_main[32];
        @(negedge clk);
        rn_valid = rv; rn_src1 = 5'(s1); rn_src2 = 5'(s2); rn_dst = 5'(d);
        rn_dst_wr = dw; rn_new_preg = 6'(np); rn_ckpt = ck;
        rec_valid = rc; rec_tag = 2'(rt); rel_valid = rl; rel_tag = 2'(lt);
        free_any = 0; pick = 0;
        for (int i = 3; i >= 0; i--) if (!mv[i]) begin free_any = 1; pick = i; end
        e.s1 = mm[s1]; e.s2 = mm[s2]; e.pd = mm[d];
        e.stall = rv && ck && !free_any;
        e.grant = rv && ck && !rc && free_any;
        e.tag = pick; e.req = req;
        sb_q.push_back(e);
        ->drv_ev;
        @(posedge clk);
        rec_ok = rc && mv[rt];
        accept = rv && !rc && !e.stall;
        for (int i = 0; i < 32; i++) old_main[i] = mm[i];
        if (rec_ok) for (int i = 0; i < 32; i++) mm[i] = mc[rt][i];
        else if (accept && dw) mm[d] = np;
        if (rl) mv[lt] = 0;
        if (rec_ok) for (int j = 0; j < 4; j++) if (ser[j] > ser[rt]) mv[j] = 0;
        if (e.grant) begin
            for (int i = 0; i < 32; i++) mc[pick][i] = old_main[i];
            mv[pick] = 1; ser[pick] = ++sctr;
        end
    endtask

    // Plain lookup, nothing else
    task automatic peek(input int s1, input int s2, input string req);
        step(0, s1, s2, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic expect_tag(input string req, input int t);
        @(negedge clk); #1;
        check(req, "grant", int'(ck_grant), 1);
        check(req, "tag", int'(ck_tag), t);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(drv_ev);
            #1;
            e = sb_q.pop_front();
            check(e.req, "src1", int'(rn_src1_preg), e.s1);
            check(e.req, "src2", int'(rn_src2_preg), e.s2);
            check(e.req, "prev", int'(rn_prev_preg), e.pd);
            check(e.req, "stall", int'(rn_stall), int'(e.stall));
            check(e.req, "grant", int'(ck_grant), int'(e.grant));
            if (e.grant) check(e.req, "tag", int'(ck_tag), e.tag);
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        for (int i = 0; i < 32; i++) mm[i] = i;
        for (int k = 0; k < 4; k++) begin mv[k] = 0; ser[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: identity mapping after reset on every register
        for (int i = 0; i < 32; i++) step(0, i, 31 - i, i, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R3: invalid rename does not write
        step(0, 0, 0, 3, 1, 60, 0, 0, 0, 0, 0, "R3");
        peek(3, 3, "R3");
        check("R3", "r3 unchanged", int'(rn_src1_preg), 3);
        // R2: same-instruction read sees old mapping
        step(1, 7, 7, 7, 1, 41, 0, 0, 0, 0, 0, "R2");
        peek(7, 0, "R3");
        check("R3", "r7 new", int'(rn_src1_preg), 41);
        // R3: no destination write flag
        step(1, 0, 0, 9, 0, 55, 0, 0, 0, 0, 0, "R3");
        peek(9, 9, "R3");
        step(1, 0, 0, 5, 1, 40, 0, 0, 0, 0, 0, "R3");
        // R4: fill the slots; snapshot excludes own write
        step(1, 5, 0, 5, 1, 50, 1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 5, 1, 51, 0, 0, 0, 0, 0, "R4");
        step(1, 5, 6, 6, 1, 52, 1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 8, 1, 53, 1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 10, 1, 54, 1, 0, 0, 0, 0, "R4");
        // R5: full -> stall, no write
        step(1, 0, 0, 11, 1, 55, 1, 0, 0, 0, 0, "R5");
        peek(11, 10, "R5");
        check("R5", "r11 unwritten", int'(rn_src1_preg), 11);
        // R8: release slot 1, it is granted again (now youngest)
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8");
        step(1, 0, 0, 12, 1, 56, 1, 0, 0, 0, 0, "R8");
        // R7: recover to slot 2 while rename in same cycle is dropped (R6)
        step(1, 0, 0, 5, 1, 57, 0, 1, 2, 0, 0, "R6");
        peek(5, 6, "R6");
        peek(8, 12, "R6");
        check("R6", "r12 restored", int'(rn_src2_preg), 12);
        step(1, 0, 0, 13, 1, 58, 1, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 14, 1, 59, 1, 0, 0, 0, 0, "R7");
        // R6: recover to the oldest slot
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        peek(5, 6, "R6");
        check("R6", "r5 from slot0", int'(rn_src1_preg), 40);
        step(1, 0, 0, 15, 1, 20, 1, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 16, 1, 21, 1, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 17, 1, 22, 1, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 18, 1, 23, 1, 0, 0, 0, 0, "R7");
        // R8: recovery to a freed slot does nothing
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, "R8");
        peek(17, 15, "R8");
        fork
            step(1, 0, 0, 19, 1, 24, 1, 0, 0, 0, 0, "R8");
            expect_tag("R8", 3);
        join
        step(1, 0, 0, 19, 1, 25, 1, 0, 0, 0, 0, "R8");

        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule